// File: doc/BRIEF.md
# Software Write-Protect Command Filter

This block sits between the host-side byte-load path of a sector-programmed nonvolatile array and the sequencer that runs erase and program. For every load window it decides one of two things. The window may go on to change the array (`commit_ok`), or it must only run the busy timer so that reads keep polling while nothing is stored (`dummy_start`). The sequencer closes a window with a one-cycle `win_end` pulse. Each byte load inside a window arrives as a one-cycle `wr_valid` beat carrying its address and data.

A persistent protect flag governs the decision. The flag is armed by a three-beat key: three fixed address/data pairs written as the first three beats of a window. A second key is identical in its first two beats and differs in the data of its third beat; it disarms the flag. While the flag is armed, only a window that opens with one of the complete keys may commit. Any other window that carries writes is turned into a dummy timer run. Key match is only attempted on the opening beats of a window. The first wrong beat abandons matching for the rest of that window. The host reset `rst_n` does not touch the flag. Only a disarm key clears it, or the separate cold-initialisation input `prot_init_n`, which models the flag state of a never-programmed part. All key addresses and data values are parameters.

Top module: `wp_cmd_filter`

## Requirements
- R1: Driving `prot_init_n` low clears `prot_on` to 0. Driving `rst_n` low and releasing it leaves `prot_on` at the value it held before.
- R2: A window whose beats 1, 2 and 3 are (KEY_A1,KEY_D1), (KEY_A2,KEY_D2) and (KEY_A3,KEY_D_ARM) sets `prot_on` to 1. The change is visible the cycle after the third beat.
- R3: A window whose first three beats are (KEY_A1,KEY_D1), (KEY_A2,KEY_D2) and (KEY_A3,KEY_D_DISARM) clears `prot_on` to 0. The change is visible the cycle after the third beat.
- R4: With `prot_on` at 0, closing a window that holds at least one write pulses `commit_ok` for one cycle, in the cycle after `win_end`.
- R5: With `prot_on` at 1, closing a window that opened with a complete arm or disarm key pulses `commit_ok` for one cycle, in the cycle after `win_end`.
- R6: With `prot_on` at 1, closing a window that holds writes but did not open with a complete key pulses `dummy_start` for one cycle, in the cycle after `win_end`. `commit_ok` stays 0 and `prot_on` is unchanged.
- R7: A beat that does not match its key step abandons matching for the rest of the window. A full key written later in the same window neither counts as a prefix nor changes `prot_on`.
- R8: A `win_end` pulse with no write since the previous window end produces neither `commit_ok` nor `dummy_start`.
- R9: A `wr_valid` beat in the same cycle as `win_end` is ignored. It does not count toward the window being closed or toward the next one.
- R10: `commit_ok` and `dummy_start` are never high together, and each is high only in the cycle after a `win_end`.
- R11: `rst_n` low clears both outputs and abandons any partly matched key. Matching restarts from the first key step on the next window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of matcher and outputs, released synchronously |
| prot_init_n | input | 1 | Asynchronous active-low cold initialisation of the protect flag |
| wr_valid | input | 1 | One-cycle byte-load beat |
| wr_addr | input | AW (18) | Address of the beat |
| wr_data | input | DW (8) | Data of the beat |
| win_end | input | 1 | One-cycle pulse from the sequencer closing the load window |
| commit_ok | output | 1 | One-cycle pulse: the closed window may program the array |
| dummy_start | output | 1 | One-cycle pulse: run the busy timer only, store nothing |
| prot_on | output | 1 | Current state of the protect flag |

## Verification
A matcher stuck in a wrong step shows at the first `win_end` after the bad beat. In a protected window the verdict flips between `commit_ok` and `dummy_start` one cycle after the close. A key that should have armed or disarmed the flag shows on `prot_on` one cycle after its third beat. A flag corrupted by reset shows on `prot_on` the moment reset ends. Random windows mix full keys, keys broken at each step, plain data and empty windows in both flag states. Every verdict and every flag transition is therefore compared in the exact cycle it is due.

// File: rtl/wpf_pkg.sv
package wpf_pkg;
  // Key matcher progress within one load window
  typedef enum logic [2:0] {
    M_IDLE = 3'd0,  // window empty, expecting key beat 1
    M_ONE  = 3'd1,  // beat 1 matched
    M_TWO  = 3'd2,  // beats 1-2 matched
    M_PRE  = 3'd3,  // full key matched, window is prefixed
    M_FAIL = 3'd4   // window holds writes without a key prefix
  } mstate_t;
endpackage

// File: rtl/wpf_rst_sync.sv
module wpf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= {q[STAGES-2:0], 1'b1};
  end

  assign srst_n = q[STAGES-1];
endmodule

// File: rtl/wpf_matcher.sv
module wpf_matcher
  import wpf_pkg::*;
#(
  parameter int          AW           = 18,
  parameter int          DW           = 8,
  parameter logic [AW-1:0] KEY_A1     = 18'h05555,
  parameter logic [DW-1:0] KEY_D1     = 8'hAA,
  parameter logic [AW-1:0] KEY_A2     = 18'h02AAA,
  parameter logic [DW-1:0] KEY_D2     = 8'h55,
  parameter logic [AW-1:0] KEY_A3     = 18'h05555,
  parameter logic [DW-1:0] KEY_D_ARM  = 8'hA0,
  parameter logic [DW-1:0] KEY_D_DISARM = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          end_i,
  output mstate_t       st_o,
  output logic          arm_o,
  output logic          disarm_o
);
  mstate_t cur, nxt;
  logic hit1, hit2, hit_arm, hit_disarm;

  assign hit1       = (addr_i == KEY_A1) && (data_i == KEY_D1);
  assign hit2       = (addr_i == KEY_A2) && (data_i == KEY_D2);
  assign hit_arm    = (addr_i == KEY_A3) && (data_i == KEY_D_ARM);
  assign hit_disarm = (addr_i == KEY_A3) && (data_i == KEY_D_DISARM);

  always_comb begin
    nxt      = cur;
    arm_o    = 1'b0;
    disarm_o = 1'b0;
    if (end_i) begin
      nxt = M_IDLE;                  // close wins over a same-cycle beat
    end else if (wr_i) begin
      unique case (cur)
        M_IDLE: nxt = hit1 ? M_ONE : M_FAIL;
        M_ONE:  nxt = hit2 ? M_TWO : M_FAIL;
        M_TWO: begin
          if (hit_arm) begin
            nxt   = M_PRE;
            arm_o = 1'b1;
          end else if (hit_disarm) begin
            nxt      = M_PRE;
            disarm_o = 1'b1;
          end else begin
            nxt = M_FAIL;
          end
        end
        default: nxt = cur;          // prefixed or failed: sticky
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= M_IDLE;
    else        cur <= nxt;
  end

  assign st_o = cur;
endmodule

// File: rtl/wpf_flag.sv
module wpf_flag (
  input  logic clk,
  input  logic init_n,
  input  logic arm_i,
  input  logic disarm_i,
  output logic prot_o
);
  logic q, d, en;

  // Only key events load the flag; host reset is not wired here.
  assign en = arm_i | disarm_i;
  assign d  = arm_i;

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) q <= 1'b0;
    else if (en) q <= d;
  end

  assign prot_o = q;
endmodule

// File: rtl/wpf_verdict.sv
module wpf_verdict
  import wpf_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    end_i,
  input  mstate_t st_i,
  input  logic    prot_i,
  output logic    commit_o,
  output logic    dummy_o
);
  logic any_wr, allow, commit_d, dummy_d;

  assign any_wr   = (st_i != M_IDLE);
  assign allow    = (st_i == M_PRE) || !prot_i;
  assign commit_d = end_i && any_wr && allow;
  assign dummy_d  = end_i && any_wr && !allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      commit_o <= 1'b0;
      dummy_o  <= 1'b0;
    end else begin
      commit_o <= commit_d;
      dummy_o  <= dummy_d;
    end
  end
endmodule

// File: rtl/wp_cmd_filter.sv
module wp_cmd_filter
  import wpf_pkg::*;
#(
  parameter int            AW           = 18,
  parameter int            DW           = 8,
  parameter int            SYNC_STAGES  = 2,
  parameter logic [AW-1:0] KEY_A1       = 18'h05555,
  parameter logic [DW-1:0] KEY_D1       = 8'hAA,
  parameter logic [AW-1:0] KEY_A2       = 18'h02AAA,
  parameter logic [DW-1:0] KEY_D2       = 8'h55,
  parameter logic [AW-1:0] KEY_A3       = 18'h05555,
  parameter logic [DW-1:0] KEY_D_ARM    = 8'hA0,
  parameter logic [DW-1:0] KEY_D_DISARM = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prot_init_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          win_end,
  output logic          commit_ok,
  output logic          dummy_start,
  output logic          prot_on
);
  logic    srst_n, sinit_n;
  mstate_t mst;
  logic    arm, disarm;

  wpf_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_host (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n));

  wpf_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_init (
    .clk(clk), .arst_n(prot_init_n), .srst_n(sinit_n));

  wpf_matcher #(
    .AW(AW), .DW(DW),
    .KEY_A1(KEY_A1), .KEY_D1(KEY_D1),
    .KEY_A2(KEY_A2), .KEY_D2(KEY_D2),
    .KEY_A3(KEY_A3), .KEY_D_ARM(KEY_D_ARM), .KEY_D_DISARM(KEY_D_DISARM)
  ) u_match (
    .clk(clk), .rst_n(srst_n),
    .wr_i(wr_valid), .addr_i(wr_addr), .data_i(wr_data), .end_i(win_end),
    .st_o(mst), .arm_o(arm), .disarm_o(disarm));

  wpf_flag u_flag (
    .clk(clk), .init_n(sinit_n),
    .arm_i(arm), .disarm_i(disarm), .prot_o(prot_on));

  wpf_verdict u_verdict (
    .clk(clk), .rst_n(srst_n), .end_i(win_end), .st_i(mst), .prot_i(prot_on),
    .commit_o(commit_ok), .dummy_o(dummy_start));
endmodule

// File: rtl/wpf_checker.sv
module wpf_checker (
  input logic clk,
  input logic rst_n,
  input logic prot_init_n,
  input logic wr_valid,
  input logic win_end,
  input logic commit_ok,
  input logic dummy_start,
  input logic prot_on
);
  // R10: verdicts are exclusive
  p_excl_verdict_r10: assert property (@(posedge clk)
    disable iff (!rst_n || !prot_init_n) !(commit_ok && dummy_start));

  // R10 / R8: a verdict only follows a window close
  p_verdict_after_end_r10: assert property (@(posedge clk)
    disable iff (!rst_n || !prot_init_n) !win_end |=> !(commit_ok || dummy_start));

  // R6: a dummy run happens only while protected
  p_dummy_needs_prot_r6: assert property (@(posedge clk)
    disable iff (!rst_n || !prot_init_n) dummy_start |-> prot_on);

  // R2 / R3: the flag moves only after a write beat
  p_flag_moves_on_write_r2: assert property (@(posedge clk)
    disable iff (!rst_n || !prot_init_n) !wr_valid |=> $stable(prot_on));

  // R9: a beat coinciding with a close never changes the flag
  p_close_beat_ignored_r9: assert property (@(posedge clk)
    disable iff (!rst_n || !prot_init_n) win_end |=> $stable(prot_on));
endmodule

bind wp_cmd_filter wpf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .prot_init_n(prot_init_n),
  .wr_valid(wr_valid), .win_end(win_end),
  .commit_ok(commit_ok), .dummy_start(dummy_start), .prot_on(prot_on));

// File: tb/tb_wp_cmd_filter.sv
`timescale 1ns/1ps
module tb_wp_cmd_filter;
  localparam int AW = 18;
  localparam int DW = 8;
  localparam logic [AW-1:0] A1 = 18'h05555;
  localparam logic [DW-1:0] D1 = 8'hAA;
  localparam logic [AW-1:0] A2 = 18'h02AAA;
  localparam logic [DW-1:0] D2 = 8'h55;
  localparam logic [AW-1:0] A3 = 18'h05555;
  localparam logic [DW-1:0] DARM = 8'hA0;
  localparam logic [DW-1:0] DDIS = 8'h20;

  logic clk = 1'b0;
  logic rst_n, prot_init_n, wr_valid, win_end;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic commit_ok, dummy_start, prot_on;

  always #2.5 clk = ~clk;

  wp_cmd_filter dut (
    .clk(clk), .rst_n(rst_n), .prot_init_n(prot_init_n),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .win_end(win_end), .commit_ok(commit_ok), .dummy_start(dummy_start),
    .prot_on(prot_on));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model: 0 empty, 1 step1 ok, 2 step2 ok, 3 prefixed, 4 unprefixed
  int m_st = 0;
  bit m_prot = 0;

  task automatic check(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  function automatic int step_model(input int s, input logic [AW-1:0] a,
                                    input logic [DW-1:0] d);
    case (s)
      0: return (a == A1 && d == D1) ? 1 : 4;
      1: return (a == A2 && d == D2) ? 2 : 4;
      2: return (a == A3 && (d == DARM || d == DDIS)) ? 3 : 4;
      default: return s;
    endcase
  endfunction

  function automatic bit [1:0] exp_verdict(input int s, input bit p);
    if (s == 0) return 2'b00;
    if (s == 3 || !p) return 2'b10;
    return 2'b01;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    int ns;
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    ns = step_model(m_st, a, d);
    if (m_st == 2 && ns == 3) m_prot = (d == DARM);
    m_st = ns;
    @(negedge clk);
    wr_valid = 1'b0;
    check(prot_on, m_prot, "R2/R3/R7 flag after beat");
  endtask

  task automatic close(input string req);
    bit [1:0] e;
    e = exp_verdict(m_st, m_prot);
    win_end = 1'b1;
    @(negedge clk);
    win_end = 1'b0;
    m_st = 0;
    check(commit_ok, e[1], {req, " commit_ok"});
    check(dummy_start, e[0], {req, " dummy_start"});
    check(prot_on, m_prot, {req, " R6 flag unchanged by close"});
    @(negedge clk);
    check(commit_ok | dummy_start, 1'b0, "R10 single-cycle verdict");
  endtask

  task automatic key(input logic [DW-1:0] last);
    wr(A1, D1); wr(A2, D2); wr(A3, last);
  endtask

  task automatic host_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_st = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got hung expected finish");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; prot_init_n = 1'b0; wr_valid = 1'b0; win_end = 1'b0;
    wr_addr = '0; wr_data = '0;
    repeat (4) @(negedge clk);
    check(prot_on, 1'b0, "R1 init clears flag");
    check(commit_ok | dummy_start, 1'b0, "R11 outputs low in reset");
    rst_n = 1'b1; prot_init_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 empty window
    close("R8 empty window");
    // R4 unprotected plain data
    wr(18'h00100, 8'h11); wr(18'h00101, 8'h22); close("R4 unprotected");
    // R2 arm
    key(DARM); check(prot_on, 1'b1, "R2 armed"); wr(18'h00200, 8'h33); close("R5 armed key");
    // R6 unprefixed while protected
    wr(18'h00300, 8'h44); close("R6 protected unprefixed");
    // R7 broken at each step, then full key later in same window
    wr(A1, 8'h00); key(DDIS); close("R7 broken step1");
    check(prot_on, 1'b1, "R7 late key ignored");
    wr(A1, D1); wr(A2, 8'h00); close("R7 broken step2");
    wr(A1, D1); wr(A2, D2); wr(A3, 8'h77); close("R7 broken step3");
    // R1 host reset keeps flag; R11 mid-key reset
    wr(A1, D1);
    host_reset();
    check(prot_on, 1'b1, "R1 flag survives rst_n");
    wr(A2, D2); wr(A3, DARM); close("R11 matcher restarted");
    // R5 prefixed with disarm, R3
    key(DDIS); check(prot_on, 1'b0, "R3 disarmed"); close("R5 disarm key");
    // R9 beat on close cycle ignored
    key(DARM);
    close("R5 arm only");
    wr_valid = 1'b1; wr_addr = A1; wr_data = D1; win_end = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0; win_end = 1'b0;
    check(commit_ok | dummy_start, 1'b0, "R9 same-cycle beat not a window");
    @(negedge clk);
    wr(A2, D2); wr(A3, DDIS); close("R9 beat did not count as step1");
    check(prot_on, 1'b1, "R9 flag kept");

    // random windows
    for (int w = 0; w < 300; w++) begin
      int kind, nb;
      kind = $urandom_range(0, 4);
      nb = $urandom_range(0, 4);
      case (kind)
        0: key(DARM);
        1: key(DDIS);
        2: begin
          int brk;
          brk = $urandom_range(0, 2);
          wr(A1, brk == 0 ? 8'h0F : D1);
          if (brk > 0) wr(A2, brk == 1 ? 8'hF0 : D2);
          if (brk > 1) wr(A3, 8'h5A);
        end
        3: wr(AW'($urandom), DW'($urandom));
        default: ;
      endcase
      if (kind != 4)
        for (int b = 0; b < nb; b++) wr(AW'($urandom), DW'($urandom));
      close("R4/R5/R6 random window");
    end

    // R1 cold init clears an armed flag
    key(DARM); close("R5 final arm");
    prot_init_n = 1'b0;
    @(negedge clk);
    m_prot = 0;
    check(prot_on, 1'b0, "R1 init clears armed flag");
    prot_init_n = 1'b1;
    repeat (3) @(negedge clk);
    wr(18'h00400, 8'h99); close("R4 after init");
    report();
  end
endmodule